// File: doc/BRIEF.md
# Cache Line Maintenance Engine

This block carries out one maintenance operation at a time on a four-way set-associative, write-back data cache whose tag, state and data storage it holds in registers. Each command brings an operand and three control bits. The bits choose how the line is found: either by an explicit set and way, or by matching a physical address against the tags of one set. They also choose what happens to the line: it can be dropped, written back and dropped, or written back and kept.

A dirty line that has to be written back goes out through a request/acknowledge port. The port carries the line address, rebuilt from the stored tag and the set, together with the line data. The valid and dirty bits change only after the acknowledge arrives. A busy/done handshake frames each command, and done carries a hit flag, a write-back flag and a multiple-match flag.

A fill port loads lines while the engine is idle. A combinational probe port reads back any line, so surrounding logic and tests can see the stored state.

Top module: `cache_maint_engine`

## Requirements
- R1: After reset, busy, done and wb_req are 0 and every line reads back invalid and clean through the probe port.
- R2: With cmd_by_addr = 0, the set index is cmd_operand[5:2] and the way is cmd_operand[1:0]. That line is acted on whatever its tag. done_hit reports whether the line was valid, and an invalid line is left untouched.
- R3: With cmd_by_addr = 1, cmd_operand is {tag[13:6], set[5:2], offset[1:0]}. Only a valid way of that set whose tag equals the tag field is acted on, and done_hit is 1.
- R4: In address mode, if no valid way matches, the command completes with done_hit = 0, no write-back and no change to any line.
- R5: With cmd_inv_only = 1, the chosen line becomes invalid and clean with no write-back, even when dirty, whatever cmd_keep_valid is.
- R6: With cmd_inv_only = 0 and cmd_keep_valid = 0 (clear), a dirty chosen line is written back and then becomes invalid.
- R7: With cmd_inv_only = 0 and cmd_keep_valid = 1 (push), a dirty chosen line is written back and then stays valid with its dirty bit cleared.
- R8: A clean chosen line under push or clear causes no write-back. Clear makes it invalid, and push leaves it valid and clean.
- R9: wb_addr is {stored tag, set, 2'b00} and wb_data is the line data. Both hold steady while wb_req is high until wb_ack, and the line state does not change before wb_ack.
- R10: A command is taken only while busy is 0, and cmd_valid while busy has no effect. done is high for exactly one cycle per command, with done_hit, done_wb and done_multi valid in that cycle. busy falls in the cycle after done.
- R11: In address mode, when several valid ways match, only the lowest-numbered of them is acted on and done_multi is 1.
- R12: fill_en writes valid = 1, the given tag, data and dirty bit into the chosen line only while busy is 0. A fill presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_by_addr | input | 1 | 1: operand is a physical address; 0: operand is set and way |
| cmd_inv_only | input | 1 | Drop the line without write-back |
| cmd_keep_valid | input | 1 | Keep the line valid after a write-back |
| cmd_operand | input | ADDR_W (14) | Address or set/way operand |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | A line was acted on (valid when done) |
| done_wb | output | 1 | A write-back took place (valid when done) |
| done_multi | output | 1 | Several ways matched (valid when done) |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | ADDR_W (14) | Write-back line address |
| wb_data | output | DATA_W (32) | Write-back line data |
| wb_ack | input | 1 | Write-back acknowledge |
| fill_en | input | 1 | Write a line (ignored while busy) |
| fill_set | input | IDX_W (4) | Fill set |
| fill_way | input | 2 | Fill way |
| fill_tag | input | TAG_W (8) | Fill tag |
| fill_data | input | DATA_W (32) | Fill data |
| fill_dirty | input | 1 | Fill dirty bit |
| probe_set | input | IDX_W (4) | Probe set |
| probe_way | input | 2 | Probe way |
| probe_valid | output | 1 | Valid bit of probed line |
| probe_dirty | output | 1 | Dirty bit of probed line |
| probe_tag | output | TAG_W (8) | Tag of probed line |
| probe_data | output | DATA_W (32) | Data of probed line |

## Verification
Two functions can land in the same cycle. The first is a pending write-back that is stalled by a late acknowledge. The second is a new command or a line fill arriving at the block's edge. The bench holds wb_ack off for several cycles and, during that stall, presents both cmd_valid and fill_en aimed at a different line. It then checks that the write-back address and data did not move and that the stalled line kept its old state until the acknowledge. After done it probes the poked line and the whole target set, and compares each with a bench-side model, to confirm that neither intruder left a trace.

// File: rtl/cme_pkg.sv
`timescale 1ns/1ps
package cme_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB,
    ST_UPDATE,
    ST_FINISH
  } cme_state_t;
endpackage

// File: rtl/cme_tag_store.sv
`timescale 1ns/1ps
module cme_tag_store
  import cme_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_tag_en,
  input  logic [IDX_W-1:0]        wr_set,
  input  logic [WAY_W-1:0]        wr_way,
  input  logic                    wr_valid,
  input  logic                    wr_dirty,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic [IDX_W-1:0]        rd_set,
  output logic [WAYS-1:0]         rd_valid,
  output logic [WAYS-1:0]         rd_dirty,
  output logic [WAYS*TAG_W-1:0]   rd_tags,
  input  logic [IDX_W-1:0]        pr_set,
  input  logic [WAY_W-1:0]        pr_way,
  output logic                    pr_valid,
  output logic                    pr_dirty,
  output logic [TAG_W-1:0]        pr_tag
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (wr_en) begin
      valid_q[wr_set][wr_way] <= wr_valid;
      dirty_q[wr_set][wr_way] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_tag_en) begin
      tag_q[wr_set][wr_way] <= wr_tag;
    end
  end

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
      assign rd_tags[w*TAG_W +: TAG_W] = tag_q[rd_set][w];
    end
  endgenerate

  assign rd_valid = valid_q[rd_set];
  assign rd_dirty = dirty_q[rd_set];
  assign pr_valid = valid_q[pr_set][pr_way];
  assign pr_dirty = dirty_q[pr_set][pr_way];
  assign pr_tag   = tag_q[pr_set][pr_way];
endmodule

// File: rtl/cme_data_store.sv
`timescale 1ns/1ps
module cme_data_store
  import cme_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_set,
  input  logic [WAY_W-1:0]  rd_way,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  pr_set,
  input  logic [WAY_W-1:0]  pr_way,
  output logic [DATA_W-1:0] pr_data
);
  logic [DATA_W-1:0] mem_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_set][wr_way] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_set][rd_way];
  assign pr_data = mem_q[pr_set][pr_way];
endmodule

// File: rtl/cme_way_select.sv
`timescale 1ns/1ps
module cme_way_select
  import cme_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic [WAYS-1:0]       way_valid,
  input  logic [WAYS*TAG_W-1:0] way_tags,
  input  logic [TAG_W-1:0]      req_tag,
  output logic                  hit,
  output logic                  multi,
  output logic [WAY_W-1:0]      hit_way
);
  logic [WAYS-1:0] match;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == req_tag);
    end
  endgenerate

  // Lowest matching way wins; scan from the top so the lowest is written last.
  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit   = |match;
  assign multi = $countones(match) > 1;
endmodule

// File: rtl/cache_maint_engine.sv
`timescale 1ns/1ps
module cache_maint_engine
  import cme_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int ADDR_W = TAG_W + IDX_W + WAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_by_addr,
  input  logic              cmd_inv_only,
  input  logic              cmd_keep_valid,
  input  logic [ADDR_W-1:0] cmd_operand,
  output logic              busy,
  output logic              done,
  output logic              done_hit,
  output logic              done_wb,
  output logic              done_multi,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  input  logic              wb_ack,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_set,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_dirty,
  input  logic [IDX_W-1:0]  probe_set,
  input  logic [WAY_W-1:0]  probe_way,
  output logic              probe_valid,
  output logic              probe_dirty,
  output logic [TAG_W-1:0]  probe_tag,
  output logic [DATA_W-1:0] probe_data
);
  localparam int SET_LO = WAY_W;
  localparam int TAG_LO = WAY_W + IDX_W;

  cme_state_t state_q, state_d;

  logic              by_addr_q, inv_q, keep_q;
  logic [ADDR_W-1:0] op_q;
  logic              hit_q, wb_need_q, multi_q;
  logic [WAY_W-1:0]  way_q;
  logic [TAG_W-1:0]  line_tag_q;
  logic [DATA_W-1:0] line_data_q;

  logic [IDX_W-1:0]     op_set;
  logic [TAG_W-1:0]     op_tag;
  logic [WAY_W-1:0]     op_way;
  logic [WAYS-1:0]      set_valid, set_dirty;
  logic [WAYS*TAG_W-1:0] set_tags;
  logic                 m_hit, m_multi;
  logic [WAY_W-1:0]     m_way;
  logic                 sel_hit, sel_multi, sel_wb;
  logic [WAY_W-1:0]     sel_way;
  logic [DATA_W-1:0]    sel_data;

  logic accept, lookup_en, fill_go, upd_go;
  logic              ts_wr_en, ts_tag_en, ts_valid, ts_dirty;
  logic [IDX_W-1:0]  ts_set;
  logic [WAY_W-1:0]  ts_way;

  assign op_set = op_q[TAG_LO-1:SET_LO];
  assign op_tag = op_q[ADDR_W-1:TAG_LO];
  assign op_way = op_q[WAY_W-1:0];

  assign accept    = cmd_valid && (state_q == ST_IDLE);
  assign lookup_en = (state_q == ST_LOOKUP);
  assign fill_go   = fill_en && (state_q == ST_IDLE);
  assign upd_go    = (state_q == ST_UPDATE) && hit_q;

  // Array write port shared by fill (idle) and state update (engine).
  always_comb begin
    ts_wr_en  = fill_go || upd_go;
    ts_tag_en = fill_go;
    ts_set    = fill_go ? fill_set : op_set;
    ts_way    = fill_go ? fill_way : way_q;
    ts_valid  = fill_go ? 1'b1 : (keep_q && !inv_q);
    ts_dirty  = fill_go ? fill_dirty : 1'b0;
  end

  cme_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ts_wr_en),
    .wr_tag_en(ts_tag_en),
    .wr_set   (ts_set),
    .wr_way   (ts_way),
    .wr_valid (ts_valid),
    .wr_dirty (ts_dirty),
    .wr_tag   (fill_tag),
    .rd_set   (op_set),
    .rd_valid (set_valid),
    .rd_dirty (set_dirty),
    .rd_tags  (set_tags),
    .pr_set   (probe_set),
    .pr_way   (probe_way),
    .pr_valid (probe_valid),
    .pr_dirty (probe_dirty),
    .pr_tag   (probe_tag)
  );

  cme_data_store #(.SETS(SETS), .DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .wr_en  (fill_go),
    .wr_set (fill_set),
    .wr_way (fill_way),
    .wr_data(fill_data),
    .rd_set (op_set),
    .rd_way (sel_way),
    .rd_data(sel_data),
    .pr_set (probe_set),
    .pr_way (probe_way),
    .pr_data(probe_data)
  );

  cme_way_select #(.TAG_W(TAG_W)) u_sel (
    .way_valid(set_valid),
    .way_tags (set_tags),
    .req_tag  (op_tag),
    .hit      (m_hit),
    .multi    (m_multi),
    .hit_way  (m_way)
  );

  always_comb begin
    if (by_addr_q) begin
      sel_way   = m_way;
      sel_hit   = m_hit;
      sel_multi = m_multi;
    end else begin
      sel_way   = op_way;
      sel_hit   = set_valid[op_way];
      sel_multi = 1'b0;
    end
    sel_wb = sel_hit && !inv_q && set_dirty[sel_way];
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (cmd_valid) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (!sel_hit)     state_d = ST_FINISH;
        else if (sel_wb)  state_d = ST_WB;
        else              state_d = ST_UPDATE;
      end
      ST_WB:     if (wb_ack) state_d = ST_UPDATE;
      ST_UPDATE: state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      by_addr_q <= 1'b0;
      inv_q     <= 1'b0;
      keep_q    <= 1'b0;
      op_q      <= '0;
    end else if (accept) begin
      by_addr_q <= cmd_by_addr;
      inv_q     <= cmd_inv_only;
      keep_q    <= cmd_keep_valid;
      op_q      <= cmd_operand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q     <= 1'b0;
      wb_need_q <= 1'b0;
      multi_q   <= 1'b0;
      way_q     <= '0;
    end else if (lookup_en) begin
      hit_q     <= sel_hit;
      wb_need_q <= sel_wb;
      multi_q   <= sel_multi;
      way_q     <= sel_way;
    end
  end

  always_ff @(posedge clk) begin
    if (lookup_en) begin
      line_tag_q  <= set_tags[sel_way*TAG_W +: TAG_W];
      line_data_q <= sel_data;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_FINISH);
  assign done_hit   = hit_q;
  assign done_wb    = wb_need_q;
  assign done_multi = multi_q;
  assign wb_req     = (state_q == ST_WB);
  assign wb_addr    = {line_tag_q, op_set, {WAY_W{1'b0}}};
  assign wb_data    = line_data_q;
endmodule

// File: rtl/cme_checker.sv
`timescale 1ns/1ps
module cme_checker #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              done_hit,
  input logic              done_wb,
  input logic              wb_req,
  input logic              wb_ack,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [DATA_W-1:0] wb_data,
  input logic              inv_q
);
  a_r9_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr) && $stable(wb_data)));

  a_r9_wb_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> busy);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r5_inv_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && inv_q) |-> !wb_req);

  a_r4_miss_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_hit) |-> !done_wb);
endmodule

bind cache_maint_engine cme_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cme_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .done_hit(done_hit),
  .done_wb (done_wb),
  .wb_req  (wb_req),
  .wb_ack  (wb_ack),
  .wb_addr (wb_addr),
  .wb_data (wb_data),
  .inv_q   (inv_q)
);

// File: tb/tb_cache_maint_engine.sv
`timescale 1ns/1ps
module tb_cache_maint_engine;
  localparam int SETS = 16, TAG_W = 8, DATA_W = 32, IDX_W = 4, ADDR_W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_by_addr = 0, cmd_inv_only = 0, cmd_keep_valid = 0;
  logic [ADDR_W-1:0] cmd_operand = '0;
  logic busy, done, done_hit, done_wb, done_multi, wb_req;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;
  logic wb_ack = 0;
  logic fill_en = 0, fill_dirty = 0;
  logic [IDX_W-1:0] fill_set = '0, probe_set = '0;
  logic [1:0] fill_way = '0, probe_way = '0;
  logic [TAG_W-1:0] fill_tag = '0;
  logic [DATA_W-1:0] fill_data = '0;
  logic probe_valid, probe_dirty;
  logic [TAG_W-1:0] probe_tag;
  logic [DATA_W-1:0] probe_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Bench-side model of the cache state
  bit               m_valid [SETS][4];
  bit               m_dirty [SETS][4];
  logic [TAG_W-1:0] m_tag   [SETS][4];
  logic [DATA_W-1:0] m_data [SETS][4];

  always #2 clk = ~clk;

  cache_maint_engine dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_by_addr(cmd_by_addr), .cmd_inv_only(cmd_inv_only),
    .cmd_keep_valid(cmd_keep_valid), .cmd_operand(cmd_operand),
    .busy(busy), .done(done), .done_hit(done_hit), .done_wb(done_wb), .done_multi(done_multi),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack(wb_ack),
    .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
    .fill_data(fill_data), .fill_dirty(fill_dirty),
    .probe_set(probe_set), .probe_way(probe_way), .probe_valid(probe_valid),
    .probe_dirty(probe_dirty), .probe_tag(probe_tag), .probe_data(probe_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic probe_line(input int s, input int w, input string req);
    probe_set = IDX_W'(s);
    probe_way = 2'(w);
    #1;
    chk(probe_valid == m_valid[s][w], req, $sformatf("valid s%0d w%0d", s, w),
        64'(probe_valid), 64'(m_valid[s][w]));
    chk(probe_dirty == m_dirty[s][w], req, $sformatf("dirty s%0d w%0d", s, w),
        64'(probe_dirty), 64'(m_dirty[s][w]));
    if (m_valid[s][w]) begin
      chk(probe_tag == m_tag[s][w] && probe_data == m_data[s][w], req,
          $sformatf("tag/data s%0d w%0d", s, w),
          {24'h0, probe_tag, probe_data}, {24'h0, m_tag[s][w], m_data[s][w]});
    end
  endtask

  task automatic fill_line(input int s, input int w, input logic [TAG_W-1:0] t,
                           input logic [DATA_W-1:0] d, input bit dty);
    @(negedge clk);
    fill_en = 1; fill_set = IDX_W'(s); fill_way = 2'(w);
    fill_tag = t; fill_data = d; fill_dirty = dty;
    @(negedge clk);
    fill_en = 0;
    m_valid[s][w] = 1; m_dirty[s][w] = dty; m_tag[s][w] = t; m_data[s][w] = d;
  endtask

  // Issue one command, serve its write-back, and check it against the model.
  task automatic run_cmd(input bit pa, input bit inv, input bit keep,
                         input logic [ADDR_W-1:0] op, input int ack_delay,
                         input bit poke, input string req);
    int s, w, hits, cyc, waited;
    bit e_hit, e_wb, e_multi, seen_wb;
    logic [ADDR_W-1:0] e_addr;
    logic [DATA_W-1:0] e_data;
    s = int'(op[5:2]);
    w = 0; hits = 0;
    if (pa) begin
      for (int k = 3; k >= 0; k--)
        if (m_valid[s][k] && m_tag[s][k] == op[13:6]) begin w = k; hits++; end
      e_hit = hits > 0;
    end else begin
      w = int'(op[1:0]);
      e_hit = m_valid[s][w];
    end
    e_multi = hits > 1;
    e_wb    = e_hit && !inv && m_dirty[s][w];
    e_addr  = {m_tag[s][w], op[5:2], 2'b00};
    e_data  = m_data[s][w];

    @(negedge clk);
    cmd_valid = 1; cmd_by_addr = pa; cmd_inv_only = inv; cmd_keep_valid = keep;
    cmd_operand = op;
    @(negedge clk);
    cmd_valid = 0;
    cyc = 0; waited = 0; seen_wb = 0;
    while (!done && cyc < 100) begin
      wb_ack = 0; cmd_valid = 0; fill_en = 0;
      if (wb_req) begin
        if (!seen_wb) begin
          chk(wb_addr == e_addr, req, "wb_addr", 64'(wb_addr), 64'(e_addr));
          chk(wb_data == e_data, req, "wb_data", 64'(wb_data), 64'(e_data));
          probe_line(s, w, req);
          if (poke) begin
            cmd_valid = 1; cmd_by_addr = 0; cmd_inv_only = 1; cmd_keep_valid = 0;
            cmd_operand = {8'h00, IDX_W'(s ^ 1), 2'd0};
            fill_en = 1; fill_set = IDX_W'(s ^ 1); fill_way = 2'd0;
            fill_tag = 8'hEE; fill_data = 32'hBAD0_BAD0; fill_dirty = 1;
          end
        end else if (waited == 1) begin
          chk(wb_addr == e_addr && wb_data == e_data, "R9", "wb held",
              {18'h0, wb_addr, wb_data}, {18'h0, e_addr, e_data});
        end
        seen_wb = 1;
        if (waited >= ack_delay) wb_ack = 1;
        waited++;
      end
      @(negedge clk);
      cyc++;
    end
    wb_ack = 0; cmd_valid = 0; fill_en = 0;
    chk(done == 1'b1, req, "done seen", 64'(done), 64'd1);
    chk(done_hit == e_hit, req, "done_hit", 64'(done_hit), 64'(e_hit));
    chk(done_wb == e_wb && seen_wb == e_wb, req, "write-back",
        {62'h0, seen_wb, done_wb}, {62'h0, e_wb, e_wb});
    chk(done_multi == e_multi, req, "done_multi", 64'(done_multi), 64'(e_multi));
    if (e_hit) begin
      m_valid[s][w] = !inv && keep;
      m_dirty[s][w] = 0;
    end
    @(negedge clk);
    chk(!done && !busy, "R10", "done one cycle, idle after", {62'h0, done, busy}, 64'd0);
    for (int k = 0; k < 4; k++) probe_line(s, k, req);
    if (poke) probe_line(s ^ 1, 0, "R12");
  endtask

  task automatic t_reset();
    chk(!busy && !done && !wb_req, "R1", "idle outputs", {61'h0, busy, done, wb_req}, 64'd0);
    for (int s = 0; s < SETS; s += 5)
      for (int k = 0; k < 4; k++) probe_line(s, k, "R1");
  endtask

  task automatic t_setway();
    fill_line(3, 2, 8'h11, 32'hA000_0001, 1);
    run_cmd(0, 0, 0, {8'h55, 4'd3, 2'd2}, 0, 0, "R6");   // clear, tag ignored (R2)
    fill_line(3, 1, 8'h22, 32'hA000_0002, 1);
    run_cmd(0, 0, 1, {8'h00, 4'd3, 2'd1}, 1, 0, "R2");   // push foreign tag
    run_cmd(0, 0, 0, {8'h00, 4'd3, 2'd2}, 0, 0, "R2");   // invalid line: no effect
  endtask

  task automatic t_addr();
    fill_line(7, 0, 8'h31, 32'hB000_0000, 0);
    fill_line(7, 2, 8'h42, 32'hB000_0002, 1);
    fill_line(7, 3, 8'h53, 32'hB000_0003, 1);
    run_cmd(1, 0, 1, {8'h42, 4'd7, 2'd1}, 2, 0, "R7");   // push way 2
    run_cmd(1, 0, 0, {8'h53, 4'd7, 2'd3}, 0, 0, "R3");   // clear way 3
    run_cmd(1, 0, 0, {8'h77, 4'd7, 2'd0}, 0, 0, "R4");   // tag miss
    run_cmd(1, 1, 0, {8'h53, 4'd7, 2'd0}, 0, 0, "R4");   // tag of invalid way
  endtask

  task automatic t_inv_only();
    fill_line(9, 1, 8'h61, 32'hC000_0001, 1);
    run_cmd(1, 1, 1, {8'h61, 4'd9, 2'd0}, 0, 0, "R5");
    fill_line(9, 0, 8'h62, 32'hC000_0000, 1);
    run_cmd(0, 1, 0, {8'h00, 4'd9, 2'd0}, 0, 0, "R5");
  endtask

  task automatic t_clean();
    fill_line(11, 0, 8'h71, 32'hD000_0000, 0);
    fill_line(11, 1, 8'h72, 32'hD000_0001, 0);
    run_cmd(1, 0, 1, {8'h71, 4'd11, 2'd0}, 0, 0, "R8");  // push clean: unchanged
    run_cmd(1, 0, 0, {8'h72, 4'd11, 2'd0}, 0, 0, "R8");  // clear clean: invalid
  endtask

  task automatic t_stall_and_poke();
    fill_line(4, 3, 8'h81, 32'hE000_0003, 1);
    fill_line(5, 0, 8'h82, 32'hE000_0050, 1);
    run_cmd(0, 0, 0, {8'h00, 4'd4, 2'd3}, 5, 1, "R9");   // late ack, poke set 5
    run_cmd(0, 0, 1, {8'h00, 4'd5, 2'd0}, 0, 0, "R10");  // poked line still dirty
  endtask

  task automatic t_multi();
    fill_line(6, 1, 8'h99, 32'hF000_0001, 1);
    fill_line(6, 3, 8'h99, 32'hF000_0003, 1);
    run_cmd(1, 0, 0, {8'h99, 4'd6, 2'd2}, 0, 0, "R11");
    run_cmd(1, 0, 0, {8'h99, 4'd6, 2'd2}, 0, 0, "R11");  // now only way 3
  endtask

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < 4; k++) begin
        m_valid[s][k] = 0; m_dirty[s][k] = 0; m_tag[s][k] = '0; m_data[s][k] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_setway();
    t_addr();
    t_inv_only();
    t_clean();
    t_stall_and_poke();
    t_multi();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule